// File: doc/BRIEF.md
# Multi-Way Translation Buffer with Ring-Keyed Address Spaces

This block holds a set of translation ways, each a small direct-indexed array of entries. An entry carries a virtual tag, a physical page base, an address-space identifier and a four-bit attribute code. Every way has its own page size, so a single virtual address indexes and compares in all ways at once. The lookup is purely combinational. It returns the translated physical address, the way and entry that matched, and a fault flag with a three-bit cause code.

Address-space identifiers are bound to privilege rings through a packed 32-bit register that holds one byte per ring. An entry hits only when its identifier is nonzero, its tag matches, and its identifier appears in that register. The ring of the hit is then compared with the ring of the access. The attribute code is decoded into read, write and execute rights, which are checked against the access type. An entry write port loads entries from software. A refill port places a page-table word into a way picked by a pre-incremented free-running counter.

Top module: `tlbr_top`

## Requirements
- R1: The ring of an entry is the lowest byte index i (0..3) for which byte i of the ring register (bits 8i+7:8i) equals the entry's identifier. An identifier found in no byte never hits. The ring register resets to 0x04030201, and `rasid_we` loads `rasid_din` at the next clock edge.
- R2: An entry whose identifier is 0 never hits, whatever its tag.
- R3: When more than one way hits, `cause` is 2 (multi-hit). When no way hits, `cause` is 1 (miss).
- R4: On a single hit whose ring is numerically lower than `lk_ring`, `cause` is 3 (privilege).
- R5: Attribute decode: a code below 12 grants read, with bit 0 adding execute and bit 1 adding write. Code 13 grants read and write. Every other code grants nothing.
- R6: Access types are 0 read, 1 write, 2 fetch and 3 reserved, which is granted nothing. A single, privileged hit that lacks the needed right gives cause 5 for a write, 6 for a fetch and 4 otherwise. A granted access gives cause 0.
- R7: Way w uses a page of 2^(PAGE_SHIFT0 + w*PAGE_STEP) bytes and indexes entries with the IDX_W virtual address bits just above the page offset. `pa` is the entry's page base with the offset bits of `lk_va` filled in. `hit_way` and `hit_idx` name the entry that hit.
- R8: Reset clears the identifier of every entry, so every lookup after reset reports a miss.
- R9: An accepted refill advances the refill counter first and writes the way given by the low two bits of the new value, so the first refill after reset goes to way 1. The entry index comes from `rf_va` in that way. The ring comes from page-table bits 5:4 (the identifier is that ring's byte), the attribute from bits 3:0, and the page base from the bits above that way's page offset. `refill_way` shows the low two counter bits.
- R10: A software write and a refill in the same cycle: the software write takes effect, the refill is dropped and the counter does not advance.
- R11: `fault` is high exactly when `cause` is nonzero, and a zero cause implies exactly one hitting way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rasid_we | input | 1 | Load the ring register |
| rasid_din | input | 32 | New ring register value |
| lk_va | input | VA_W | Lookup virtual address |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_ring | input | 2 | Ring of the current access |
| pa | output | PA_W | Translated physical address |
| fault | output | 1 | Lookup did not succeed |
| cause | output | 3 | Fault cause, 0 on success |
| hit_way | output | WAY_W | Way that hit |
| hit_idx | output | IDX_W | Entry index within that way |
| wr_en | input | 1 | Software entry write |
| wr_way | input | WAY_W | Target way of the write |
| wr_idx | input | IDX_W | Target entry of the write |
| wr_va | input | VA_W | Virtual address giving the tag |
| wr_ppn | input | PA_W | Physical page base |
| wr_asid | input | 8 | Address-space identifier |
| wr_attr | input | 4 | Attribute code |
| rf_en | input | 1 | Refill request |
| rf_va | input | VA_W | Virtual address being refilled |
| rf_pte | input | PA_W | Page-table word for the refill |
| refill_way | output | 2 | Low two bits of the refill counter |

## Verification
The checker assumes that the lookup inputs are steady at each sampling edge and that the reset is held for at least one edge. It also assumes that the refill counter moves only through accepted refills. The stimulus changes inputs only on falling edges. It pulses the write and refill ports for exactly one rising edge each, and it asserts reset at the start of every scenario. Multi-hit cases are built on purpose from entries in two ways that share a virtual page. Every other scenario places its entries so that only one way can match.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
   localparam int ASID_W = 8;
   localparam int NRING  = 4;

   typedef enum logic [2:0] {
      TC_OK         = 3'd0,
      TC_MISS       = 3'd1,
      TC_MULTI      = 3'd2,
      TC_PRIV       = 3'd3,
      TC_LOAD_DENY  = 3'd4,
      TC_STORE_DENY = 3'd5,
      TC_FETCH_DENY = 3'd6
   } tlbr_cause_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } tlbr_acc_e;

   // {found, ring}: the lowest byte holding the identifier wins
   function automatic logic [2:0] ring_of(input logic [ASID_W-1:0] id,
                                          input logic [NRING*ASID_W-1:0] rmap);
      logic [2:0] res;
      res = 3'b000;
      for (int i = NRING - 1; i >= 0; i--) begin
         if (rmap[i*ASID_W +: ASID_W] == id) res = {1'b1, 2'(i)};
      end
      return res;
   endfunction
endpackage

// File: rtl/tlbr_rights.sv
module tlbr_rights
   import tlbr_pkg::*;
(
   input  logic [3:0] attr,
   input  logic [1:0] acc,
   output logic       granted
);
   logic can_r, can_w, can_x;

   always_comb begin
      can_r = 1'b0;
      can_w = 1'b0;
      can_x = 1'b0;
      if (attr < 4'd12) begin
         can_r = 1'b1;
         can_x = attr[0];
         can_w = attr[1];
      end else if (attr == 4'd13) begin
         can_r = 1'b1;
         can_w = 1'b1;
      end
      case (acc)
         ACC_RD:  granted = can_r;
         ACC_WR:  granted = can_w;
         ACC_EX:  granted = can_x;
         default: granted = 1'b0;
      endcase
   end
endmodule

// File: rtl/tlbr_refill_ctr.sv
module tlbr_refill_ctr #(
   parameter int CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   output logic [1:0] next_way,
   output logic [1:0] cur_way
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   assign cnt_nx   = cnt_q + CNT_W'(1);
   assign next_way = cnt_nx[1:0];
   assign cur_way  = cnt_q[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/tlbr_way.sv
module tlbr_way
   import tlbr_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int IDX_W      = 2,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [VA_W-1:0]           lk_va,
   input  logic [NRING*ASID_W-1:0]   rmap,
   input  logic                      we,
   input  logic                      w_use_va,
   input  logic [IDX_W-1:0]          w_idx,
   input  logic [VA_W-1:0]           w_va,
   input  logic [PA_W-1:0]           w_ppn,
   input  logic [ASID_W-1:0]         w_asid,
   input  logic [3:0]                w_attr,
   output logic                      hit,
   output logic [1:0]                ring,
   output logic [3:0]                attr,
   output logic [PA_W-1:0]           pa,
   output logic [IDX_W-1:0]          idx
);
   localparam int NENT   = 1 << IDX_W;
   localparam int TAG_LO = PAGE_SHIFT + IDX_W;
   localparam logic [VA_W-1:0] TAG_MASK = {VA_W{1'b1}} << TAG_LO;
   localparam logic [PA_W-1:0] PPN_MASK = {PA_W{1'b1}} << PAGE_SHIFT;

   logic [VA_W-1:0]   tag_q  [NENT];
   logic [PA_W-1:0]   ppn_q  [NENT];
   logic [ASID_W-1:0] asid_q [NENT];
   logic [3:0]        attr_q [NENT];

   logic [IDX_W-1:0] wsel;
   assign wsel = w_use_va ? w_va[PAGE_SHIFT +: IDX_W] : w_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++) begin
            tag_q[e]  <= '0;
            ppn_q[e]  <= '0;
            asid_q[e] <= '0;
            attr_q[e] <= '0;
         end
      end else if (we) begin
         tag_q[wsel]  <= w_va & TAG_MASK;
         ppn_q[wsel]  <= w_ppn & PPN_MASK;
         asid_q[wsel] <= w_asid;
         attr_q[wsel] <= w_attr;
      end
   end

   logic [2:0] rinfo;

   always_comb begin
      idx   = lk_va[PAGE_SHIFT +: IDX_W];
      rinfo = ring_of(asid_q[idx], rmap);
      hit   = (asid_q[idx] != '0) && rinfo[2] &&
              ((lk_va & TAG_MASK) == tag_q[idx]);
      ring  = rinfo[1:0];
      attr  = attr_q[idx];
      pa    = ppn_q[idx] | (PA_W'(lk_va) & ~PPN_MASK);
   end
endmodule

// File: rtl/tlbr_top.sv
module tlbr_top
   import tlbr_pkg::*;
#(
   parameter int VA_W         = 32,
   parameter int PA_W         = 32,
   parameter int NWAYS        = 4,
   parameter int IDX_W        = 2,
   parameter int PAGE_SHIFT0  = 12,
   parameter int PAGE_STEP    = 2,
   parameter int REFILL_CNT_W = 4,
   parameter logic [31:0] RMAP_INIT = 32'h0403_0201,
   localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rasid_we,
   input  logic [31:0]      rasid_din,
   input  logic [VA_W-1:0]  lk_va,
   input  logic [1:0]       lk_acc,
   input  logic [1:0]       lk_ring,
   output logic [PA_W-1:0]  pa,
   output logic             fault,
   output logic [2:0]       cause,
   output logic [WAY_W-1:0] hit_way,
   output logic [IDX_W-1:0] hit_idx,
   input  logic             wr_en,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VA_W-1:0]  wr_va,
   input  logic [PA_W-1:0]  wr_ppn,
   input  logic [7:0]       wr_asid,
   input  logic [3:0]       wr_attr,
   input  logic             rf_en,
   input  logic [VA_W-1:0]  rf_va,
   input  logic [PA_W-1:0]  rf_pte,
   output logic [1:0]       refill_way
);
   localparam int CNT_HIT_W = $clog2(NWAYS + 1);
   localparam int MAX_SHIFT = PAGE_SHIFT0 + (NWAYS - 1) * PAGE_STEP;

   if (NWAYS < 4) begin : g_chk_ways
      $error("tlbr_top: refill way selection needs NWAYS >= 4");
   end
   if (MAX_SHIFT + IDX_W >= VA_W) begin : g_chk_va
      $error("tlbr_top: largest way page plus index exceeds VA_W");
   end
   if (MAX_SHIFT >= PA_W) begin : g_chk_pa
      $error("tlbr_top: largest way page exceeds PA_W");
   end
   if (REFILL_CNT_W < 2) begin : g_chk_cnt
      $error("tlbr_top: refill counter needs at least two bits");
   end

   // ring-to-identifier register
   logic [31:0] rmap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rmap_q <= RMAP_INIT;
      else if (rasid_we) rmap_q <= rasid_din;
   end

   // refill way selection
   logic       refill_go;
   logic [1:0] rf_way;
   assign refill_go = rf_en && !wr_en;

   tlbr_refill_ctr #(.CNT_W(REFILL_CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (refill_go),
      .next_way (rf_way),
      .cur_way  (refill_way)
   );

   logic [1:0]        rf_ring;
   logic [ASID_W-1:0] rf_asid;
   assign rf_ring = rf_pte[5:4];
   assign rf_asid = rmap_q[rf_ring*ASID_W +: ASID_W];

   // shared write data
   logic [VA_W-1:0]   m_va;
   logic [PA_W-1:0]   m_ppn;
   logic [ASID_W-1:0] m_asid;
   logic [3:0]        m_attr;
   assign m_va   = wr_en ? wr_va   : rf_va;
   assign m_ppn  = wr_en ? wr_ppn  : rf_pte;
   assign m_asid = wr_en ? wr_asid : rf_asid;
   assign m_attr = wr_en ? wr_attr : rf_pte[3:0];

   logic [NWAYS-1:0] way_hit;
   logic [1:0]       way_ring [NWAYS];
   logic [3:0]       way_attr [NWAYS];
   logic [PA_W-1:0]  way_pa   [NWAYS];
   logic [IDX_W-1:0] way_idx  [NWAYS];

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic we_w;
      assign we_w = (wr_en && (wr_way == WAY_W'(w))) ||
                    (refill_go && (WAY_W'(rf_way) == WAY_W'(w)));

      tlbr_way #(
         .VA_W       (VA_W),
         .PA_W       (PA_W),
         .IDX_W      (IDX_W),
         .PAGE_SHIFT (PAGE_SHIFT0 + w * PAGE_STEP)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_va    (lk_va),
         .rmap     (rmap_q),
         .we       (we_w),
         .w_use_va (!wr_en),
         .w_idx    (wr_idx),
         .w_va     (m_va),
         .w_ppn    (m_ppn),
         .w_asid   (m_asid),
         .w_attr   (m_attr),
         .hit      (way_hit[w]),
         .ring     (way_ring[w]),
         .attr     (way_attr[w]),
         .pa       (way_pa[w]),
         .idx      (way_idx[w])
      );
   end

   // hit reduction: count and pick the lowest hitting way
   logic [CNT_HIT_W-1:0] nhit;
   logic [WAY_W-1:0]     sel;
   always_comb begin
      nhit = '0;
      sel  = '0;
      for (int w = NWAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) begin
            nhit = nhit + CNT_HIT_W'(1);
            sel  = WAY_W'(w);
         end
      end
   end

   logic [1:0] sel_ring;
   logic [1:0] cur_ring;
   logic       granted;
   assign sel_ring = way_ring[sel];
   assign cur_ring = lk_ring;

   tlbr_rights u_rights (
      .attr    (way_attr[sel]),
      .acc     (lk_acc),
      .granted (granted)
   );

   tlbr_cause_e cz;
   always_comb begin
      if (nhit > CNT_HIT_W'(1))      cz = TC_MULTI;
      else if (nhit == '0)           cz = TC_MISS;
      else if (sel_ring < cur_ring)  cz = TC_PRIV;
      else if (!granted) begin
         case (lk_acc)
            ACC_WR:  cz = TC_STORE_DENY;
            ACC_EX:  cz = TC_FETCH_DENY;
            default: cz = TC_LOAD_DENY;
         endcase
      end else                       cz = TC_OK;
   end

   assign cause   = cz;
   assign fault   = (cz != TC_OK);
   assign pa      = way_pa[sel];
   assign hit_way = sel;
   assign hit_idx = way_idx[sel];
endmodule

// File: rtl/tlbr_chk.sv
module tlbr_chk #(
   parameter int NWAYS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NWAYS-1:0] way_hit,
   input logic [2:0]       cause,
   input logic             fault,
   input logic [1:0]       sel_ring,
   input logic [1:0]       cur_ring,
   input logic             refill_go,
   input logic [1:0]       refill_way
);
   p_multi_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(way_hit) > 1) |-> (cause == 3'd2));

   p_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (way_hit == '0) |-> (cause == 3'd1));

   p_priv_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause == 3'd3) |-> (sel_ring < cur_ring));

   p_ok_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault) |-> ($countones(way_hit) == 1));

   p_refill_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      refill_go |=> (refill_way == $past(refill_way) + 2'd1));

   p_refill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!refill_go) |=> $stable(refill_way));
endmodule

bind tlbr_top tlbr_chk #(.NWAYS(NWAYS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .way_hit    (way_hit),
   .cause      (cause),
   .fault      (fault),
   .sel_ring   (sel_ring),
   .cur_ring   (cur_ring),
   .refill_go  (refill_go),
   .refill_way (refill_way)
);

// File: tb/tlbr_top_test.sv
`timescale 1ns/1ps
module tlbr_top_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rasid_we;
   logic [31:0] rasid_din;
   logic [31:0] lk_va;
   logic [1:0]  lk_acc;
   logic [1:0]  lk_ring;
   logic [31:0] pa;
   logic        fault;
   logic [2:0]  cause;
   logic [1:0]  hit_way;
   logic [1:0]  hit_idx;
   logic        wr_en;
   logic [1:0]  wr_way;
   logic [1:0]  wr_idx;
   logic [31:0] wr_va;
   logic [31:0] wr_ppn;
   logic [7:0]  wr_asid;
   logic [3:0]  wr_attr;
   logic        rf_en;
   logic [31:0] rf_va;
   logic [31:0] rf_pte;
   logic [1:0]  refill_way;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   tlbr_top uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rasid_we = 0; rasid_din = 0; wr_en = 0; rf_en = 0;
      wr_way = 0; wr_idx = 0; wr_va = 0; wr_ppn = 0; wr_asid = 0; wr_attr = 0;
      rf_va = 0; rf_pte = 0; lk_va = 0; lk_acc = 0; lk_ring = 0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put(input logic [1:0] w, input logic [1:0] i, input logic [31:0] va,
                      input logic [31:0] ppn, input logic [7:0] id, input logic [3:0] at);
      wr_en = 1; wr_way = w; wr_idx = i; wr_va = va; wr_ppn = ppn; wr_asid = id; wr_attr = at;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic refill(input logic [31:0] va, input logic [31:0] pte);
      rf_en = 1; rf_va = va; rf_pte = pte;
      @(negedge clk);
      rf_en = 0;
   endtask

   task automatic set_map(input logic [31:0] v);
      rasid_we = 1; rasid_din = v;
      @(negedge clk);
      rasid_we = 0;
   endtask

   task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] rg);
      lk_va = va; lk_acc = acc; lk_ring = rg;
      #2;
   endtask

   function automatic logic [2:0] exp_rights(input logic [3:0] a, input logic [1:0] acc);
      logic r, w, x;
      r = (a < 12) || (a == 13);
      w = ((a < 12) && a[1]) || (a == 13);
      x = (a < 12) && a[0];
      case (acc)
         2'd0: return r ? 3'd0 : 3'd4;
         2'd1: return w ? 3'd0 : 3'd5;
         2'd2: return x ? 3'd0 : 3'd6;
         default: return 3'd4;
      endcase
   endfunction

   task automatic t_reset();
      do_reset();
      look(32'h0040_1000, 2'd0, 2'd0);
      chk("R8 miss after reset", cause, 3'd1);
      chk("R11 fault on miss", fault, 1'b1);
      chk("R9 counter reset", refill_way, 2'd0);
   endtask

   task automatic t_basic();
      do_reset();
      put(2'd0, 2'd1, 32'h0040_1000, 32'h1234_5000, 8'd1, 4'd3);
      look(32'h0040_1ABC, 2'd0, 2'd0);
      chk("R7 cause ok", cause, 3'd0);
      chk("R11 no fault", fault, 1'b0);
      chk("R7 pa", pa, 32'h1234_5ABC);
      chk("R7 way", hit_way, 2'd0);
      chk("R7 idx", hit_idx, 2'd1);
      look(32'h0040_1ABC, 2'd0, 2'd1);
      chk("R4 ring0 entry at ring1", cause, 3'd3);
      put(2'd3, 2'd2, 32'h0AA8_0000, 32'h3300_0000, 8'd3, 4'd3);
      look(32'h0AA8_1234, 2'd0, 2'd2);
      chk("R1 id3 ring2 allowed", cause, 3'd0);
      chk("R7 pa way3", pa, 32'h3300_1234);
      chk("R7 way3", hit_way, 2'd3);
      look(32'h0AA8_1234, 2'd0, 2'd3);
      chk("R4 ring2 entry at ring3", cause, 3'd3);
      look(32'h0041_1ABC, 2'd0, 2'd0);
      chk("R7 tag mismatch misses", cause, 3'd1);
   endtask

   task automatic t_asid_map();
      do_reset();
      put(2'd0, 2'd0, 32'h0010_0000, 32'h0000_5000, 8'd9, 4'd1);
      look(32'h0010_0010, 2'd0, 2'd0);
      chk("R1 unmapped id misses", cause, 3'd1);
      set_map(32'h0403_0209);
      look(32'h0010_0010, 2'd0, 2'd0);
      chk("R1 remapped id hits", cause, 3'd0);
      set_map(32'h0909_0201);
      look(32'h0010_0010, 2'd0, 2'd2);
      chk("R1 lowest byte gives ring2", cause, 3'd0);
      look(32'h0010_0010, 2'd0, 2'd3);
      chk("R1 lowest byte not ring3", cause, 3'd3);
   endtask

   task automatic t_asid_zero();
      do_reset();
      set_map(32'h0403_0200);
      put(2'd0, 2'd0, 32'h0020_0000, 32'h0000_1000, 8'd0, 4'd3);
      look(32'h0020_0000, 2'd0, 2'd0);
      chk("R2 id0 never hits", cause, 3'd1);
   endtask

   task automatic t_multi();
      do_reset();
      put(2'd0, 2'd1, 32'h0040_1000, 32'h1234_5000, 8'd1, 4'd3);
      put(2'd1, 2'd0, 32'h0040_1000, 32'h5555_0000, 8'd2, 4'd3);
      look(32'h0040_1ABC, 2'd0, 2'd0);
      chk("R3 multi hit", cause, 3'd2);
      chk("R11 fault on multi", fault, 1'b1);
   endtask

   task automatic t_rights();
      logic [3:0] codes [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
      do_reset();
      for (int c = 0; c < 9; c++) begin
         put(2'd2, 2'd2, 32'h0082_0000, 32'h0100_0000, 8'd1, codes[c]);
         for (int a = 0; a < 4; a++) begin
            look(32'h0082_0040, 2'(a), 2'd0);
            chk($sformatf("R5 R6 attr %0d acc %0d", codes[c], a), cause, exp_rights(codes[c], 2'(a)));
         end
      end
   endtask

   task automatic t_refill();
      do_reset();
      refill(32'h0123_4000, 32'h0ABC_0023);
      chk("R9 first refill way1", refill_way, 2'd1);
      look(32'h0123_4567, 2'd0, 2'd2);
      chk("R9 refill hit", cause, 3'd0);
      chk("R9 refill pa", pa, 32'h0ABC_0567);
      chk("R9 refill way", hit_way, 2'd1);
      chk("R9 refill idx", hit_idx, 2'd1);
      look(32'h0123_4567, 2'd1, 2'd3);
      chk("R9 ring from pte bits", cause, 3'd3);
      refill(32'h0200_0000, 32'h0000_0001);
      chk("R9 second refill way2", refill_way, 2'd2);
      refill(32'h0300_0000, 32'h0000_0001);
      chk("R9 third refill way3", refill_way, 2'd3);
      refill(32'h0500_0000, 32'h0777_1001);
      chk("R9 wrap to way0", refill_way, 2'd0);
      look(32'h0500_0ABC, 2'd0, 2'd0);
      chk("R9 way0 entry hit", cause, 3'd0);
      chk("R9 way0 pa", pa, 32'h0777_1ABC);
      chk("R9 way0 selected", hit_way, 2'd0);
   endtask

   task automatic t_precedence();
      do_reset();
      wr_en = 1; wr_way = 2'd0; wr_idx = 2'd1; wr_va = 32'h0040_1000;
      wr_ppn = 32'h1234_5000; wr_asid = 8'd1; wr_attr = 4'd3;
      rf_en = 1; rf_va = 32'h0123_4000; rf_pte = 32'h0ABC_0003;
      @(negedge clk);
      wr_en = 0; rf_en = 0;
      chk("R10 counter held", refill_way, 2'd0);
      look(32'h0123_4000, 2'd0, 2'd0);
      chk("R10 refill dropped", cause, 3'd1);
      look(32'h0040_1000, 2'd0, 2'd0);
      chk("R10 write kept", cause, 3'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_asid_map();
      t_asid_zero();
      t_multi();
      t_rights();
      t_refill();
      t_precedence();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule